// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a 32-bit processor core that finishes every instruction in the span between one rising clock edge and the next. It executes a reduced load/store instruction subset: five register-to-register operations (add, sub, and, or, signed set-on-less-than), a word load, a word store, a branch on equal and an unconditional jump. The program counter, register file and data memory are the only state. Everything else (decode, operand selection, the ALU and the next-address logic) is combinational between them.

The main decoder turns the 6-bit opcode into the datapath selects and a 2-bit operation class. A second decoder turns that class, together with the function field of register-format words, into a 3-bit ALU code. Instruction and data memories are internal word arrays indexed by address bits [31:2], which a testbench fills before it releases reset. The write ports of the register file and of data memory appear on the core's outputs so that each instruction's effect can be observed.

Top module: `sc_core`

## Requirements
- R1: While reset (active-low `rst_n`) is low the PC is 0. After reset is released, every instruction other than a taken branch or a jump advances the PC by 4, and each cycle the word at PC is fetched.
- R2: Register-format words (opcode 000000) write the ALU result to the rd field [15:11]. The function codes are 100000 add, 100010 sub, 100100 and, 100101 or.
- R3: Function code 101010 writes 1 into rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R4: A load (opcode 100011) reads the data word at R[rs] + sign-extended imm[15:0] and writes it to rt [20:16]. Memory is indexed by address bits [31:2].
- R5: A store (opcode 101011) writes R[rt] to address R[rs] + sign-extended imm and writes no register. A later load from that address returns the stored word.
- R6: A branch (opcode 000100) goes to PC+4 + (sext(imm) << 2) when R[rs] equals R[rt], and to PC+4 otherwise. Negative offsets move backwards. A branch writes neither the register file nor memory.
- R7: A jump (opcode 000010) loads the PC with {(PC+4)[31:28], addr[25:0], 2'b00}.
- R8: Register 0 reads as zero, and a write aimed at it is dropped (no write is reported on the port).
- R9: Any other opcode writes nothing and only advances the PC by 4.
- R10: A register read in the same cycle as a write to that register returns the old value. The new value is visible to the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_out | output | 32 | Current program counter |
| instr_out | output | 32 | Instruction fetched at the current PC |
| rf_we | output | 1 | Register write occurs at the coming edge |
| rf_waddr | output | 5 | Destination register number |
| rf_wdata | output | 32 | Data written to the destination register |
| dm_we | output | 1 | Data memory write occurs at the coming edge |
| dm_addr | output | 32 | Data memory byte address (ALU result) |
| dm_wdata | output | 32 | Data written to memory (R[rt]) |

## Verification
Two functions share one cycle here: an instruction reads a register that it also writes at the closing edge, and a store is followed at once by a load of the same address. The bench provokes the first with `add r1,r1,r1` followed by an instruction that reads r1. It expects the doubled old value from the first instruction and the updated value in the second. It provokes the second with a store through a base register and a negative offset, then a load of the same word through an absolute offset. The data seen on the register write port must be the stored word.

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] pc_out,
  output logic [31:0] instr_out,
  output logic        rf_we,
  output logic [4:0]  rf_waddr,
  output logic [31:0] rf_wdata,
  output logic        dm_we,
  output logic [31:0] dm_addr,
  output logic [31:0] dm_wdata
);
  localparam int IA_W = $clog2(IMEM_WORDS);
  localparam int DA_W = $clog2(DMEM_WORDS);
  localparam logic [5:0] OP_RT = 6'b000000, OP_LW = 6'b100011, OP_SW = 6'b101011,
                         OP_BEQ = 6'b000100, OP_J = 6'b000010;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] regs [32];

  logic [31:0] pc, instr, rd_a, rd_b, imm_ext, opnd_b, alu_y;
  logic [31:0] pc_seq, pc_br, pc_jmp, pc_nxt;
  logic [5:0]  opc, fn;
  logic [4:0]  ra, rb, dst;
  logic [1:0]  alu_op;
  logic [2:0]  alu_ctl;
  logic        sel_rd, sel_imm, sel_mem, wr_reg, wr_mem, is_br, is_jmp, zero;

  assign instr   = imem[pc[IA_W+1:2]];
  assign opc     = instr[31:26];
  assign ra      = instr[25:21];
  assign rb      = instr[20:16];
  assign fn      = instr[5:0];
  assign imm_ext = {{16{instr[15]}}, instr[15:0]};

  always_comb begin
    sel_rd = 1'b0; sel_imm = 1'b0; sel_mem = 1'b0; wr_reg = 1'b0;
    wr_mem = 1'b0; is_br = 1'b0; is_jmp = 1'b0; alu_op = 2'b00;
    case (opc)
      OP_RT:  begin sel_rd = 1'b1; wr_reg = 1'b1; alu_op = 2'b10; end
      OP_LW:  begin sel_imm = 1'b1; sel_mem = 1'b1; wr_reg = 1'b1; end
      OP_SW:  begin sel_imm = 1'b1; wr_mem = 1'b1; end
      OP_BEQ: begin is_br = 1'b1; alu_op = 2'b01; end
      OP_J:   is_jmp = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (alu_op)
      2'b00: alu_ctl = 3'b010;
      2'b01: alu_ctl = 3'b110;
      default:
        case (fn)
          6'b100010: alu_ctl = 3'b110;
          6'b100100: alu_ctl = 3'b000;
          6'b100101: alu_ctl = 3'b001;
          6'b101010: alu_ctl = 3'b111;
          default:   alu_ctl = 3'b010;
        endcase
    endcase
  end

  assign rd_a   = (ra == 5'd0) ? 32'd0 : regs[ra];
  assign rd_b   = (rb == 5'd0) ? 32'd0 : regs[rb];
  assign opnd_b = sel_imm ? imm_ext : rd_b;

  always_comb begin
    case (alu_ctl)
      3'b000:  alu_y = rd_a & opnd_b;
      3'b001:  alu_y = rd_a | opnd_b;
      3'b110:  alu_y = rd_a - opnd_b;
      3'b111:  alu_y = {31'd0, $signed(rd_a) < $signed(opnd_b)};
      default: alu_y = rd_a + opnd_b;
    endcase
  end
  assign zero = (alu_y == 32'd0);

  assign pc_seq = pc + 32'd4;
  assign pc_br  = pc_seq + {imm_ext[29:0], 2'b00};
  assign pc_jmp = {pc_seq[31:28], instr[25:0], 2'b00};
  assign pc_nxt = is_jmp ? pc_jmp : ((is_br && zero) ? pc_br : pc_seq);

  assign dst      = sel_rd ? instr[15:11] : rb;
  assign rf_we    = wr_reg && (dst != 5'd0);
  assign rf_waddr = dst;
  assign rf_wdata = sel_mem ? dmem[alu_y[DA_W+1:2]] : alu_y;
  assign dm_we    = wr_mem;
  assign dm_addr  = alu_y;
  assign dm_wdata = rd_b;
  assign pc_out    = pc;
  assign instr_out = instr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) regs[i] <= 32'd0;
    end else begin
      pc <= pc_nxt;
      if (rf_we) regs[dst] <= rf_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_mem) dmem[alu_y[DA_W+1:2]] <= rd_b;
  end
endmodule

// File: rtl/sc_core_checker.sv
`timescale 1ns/1ps
module sc_core_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc_out,
  input logic [31:0] instr_out,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic        dm_we
);
  logic [5:0]  opc;
  logic [31:0] seq;
  assign opc = instr_out[31:26];
  assign seq = pc_out + 32'd4;

  p_pc_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_out[1:0] == 2'b00);

  p_seq_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'b000000 || opc == 6'b100011 || opc == 6'b101011)
      |=> pc_out == $past(pc_out) + 32'd4);

  p_rdst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'b000000 && rf_we) |-> rf_waddr == instr_out[15:11]);

  p_ldst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'b100011 && rf_we) |-> rf_waddr == instr_out[20:16]);

  p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'b101011) |-> (dm_we && !rf_we));

  p_beq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'b000100) |-> (!dm_we && !rf_we));

  p_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == 6'b000010)
      |=> pc_out == {$past(seq[31:28]), $past(instr_out[25:0]), 2'b00});

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != 5'd0);

  p_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(opc == 6'b000000 || opc == 6'b100011 || opc == 6'b101011 ||
      opc == 6'b000100 || opc == 6'b000010)
      |-> (!rf_we && !dm_we));
endmodule

bind sc_core sc_core_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pc_out(pc_out), .instr_out(instr_out),
  .rf_we(rf_we), .rf_waddr(rf_waddr), .dm_we(dm_we)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] pc_out, instr_out, rf_wdata, dm_addr, dm_wdata;
  logic [4:0] rf_waddr;
  logic rf_we, dm_we;
  int checks = 0;
  int errors = 0;

  localparam logic [31:0] NOP = 32'hFC00_0000;

  always #10 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst_n(rst_n), .pc_out(pc_out), .instr_out(instr_out),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] s, t, d, input logic [5:0] f);
    return {6'b000000, s, t, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s, t,
                                        input logic [15:0] imm);
    return {op, s, t, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] a);
    return {6'b000010, a};
  endfunction
  function automatic logic [31:0] lw(input logic [4:0] s, t, input logic [15:0] imm);
    return enc_i(6'b100011, s, t, imm);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_wr(input string req, input logic [4:0] a, input logic [31:0] d);
    chk(req, "rf_we", {31'd0, rf_we}, 32'd1);
    chk(req, "rf_waddr", {27'd0, rf_waddr}, {27'd0, a});
    chk(req, "rf_wdata", rf_wdata, d);
  endtask

  task automatic hold();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      uut.imem[i] = NOP;
      uut.dmem[i] = 32'd0;
    end
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    hold();
    @(posedge clk);
    #1;
    chk("R1", "pc in reset", pc_out, 32'd0);
    release_rst();
    chk("R1", "pc after release", pc_out, 32'd0);
    chk("R1", "fetched word", instr_out, NOP);
    step();
    chk("R1", "pc +4", pc_out, 32'd4);
    step();
    chk("R1", "pc +8", pc_out, 32'd8);
  endtask

  task automatic t_alu();
    hold();
    uut.dmem[0] = 32'd7;
    uut.dmem[1] = 32'hFFFF_FFFD;
    uut.imem[0] = lw(5'd0, 5'd1, 16'd0);
    uut.imem[1] = lw(5'd0, 5'd2, 16'd4);
    uut.imem[2] = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);
    uut.imem[3] = enc_r(5'd1, 5'd2, 5'd4, 6'b100010);
    uut.imem[4] = enc_r(5'd1, 5'd2, 5'd5, 6'b100100);
    uut.imem[5] = enc_r(5'd1, 5'd2, 5'd6, 6'b100101);
    uut.imem[6] = enc_r(5'd2, 5'd1, 5'd7, 6'b101010);
    uut.imem[7] = enc_r(5'd1, 5'd2, 5'd8, 6'b101010);
    uut.imem[8] = enc_r(5'd1, 5'd1, 5'd1, 6'b100000);
    uut.imem[9] = enc_r(5'd1, 5'd0, 5'd9, 6'b100000);
    release_rst();
    chk_wr("R4", 5'd1, 32'd7);
    step(); chk_wr("R4", 5'd2, 32'hFFFF_FFFD);
    step(); chk_wr("R2", 5'd3, 32'd4);
    step(); chk_wr("R2", 5'd4, 32'd10);
    step(); chk_wr("R2", 5'd5, 32'd5);
    step(); chk_wr("R2", 5'd6, 32'hFFFF_FFFF);
    step(); chk_wr("R3", 5'd7, 32'd1);
    step(); chk_wr("R3", 5'd8, 32'd0);
    step(); chk_wr("R10", 5'd1, 32'd14);
    step(); chk_wr("R10", 5'd9, 32'd14);
    chk("R1", "pc after ten", pc_out, 32'd36);
  endtask

  task automatic t_mem();
    hold();
    uut.dmem[0] = 32'h1234_5678;
    uut.dmem[2] = 32'd16;
    uut.imem[0] = lw(5'd0, 5'd1, 16'd0);
    uut.imem[1] = lw(5'd0, 5'd2, 16'd8);
    uut.imem[2] = enc_i(6'b101011, 5'd2, 5'd1, 16'hFFFC);
    uut.imem[3] = lw(5'd0, 5'd3, 16'd12);
    release_rst();
    step(); step();
    chk("R5", "dm_we", {31'd0, dm_we}, 32'd1);
    chk("R5", "rf_we", {31'd0, rf_we}, 32'd0);
    chk("R5", "dm_addr", dm_addr, 32'd12);
    chk("R5", "dm_wdata", dm_wdata, 32'h1234_5678);
    step();
    chk("R5", "dm_we after", {31'd0, dm_we}, 32'd0);
    chk_wr("R5", 5'd3, 32'h1234_5678);
  endtask

  task automatic t_branch();
    hold();
    uut.dmem[0] = 32'd5;
    uut.dmem[1] = 32'd5;
    uut.dmem[2] = 32'd6;
    uut.imem[0] = lw(5'd0, 5'd1, 16'd0);
    uut.imem[1] = lw(5'd0, 5'd2, 16'd4);
    uut.imem[2] = lw(5'd0, 5'd3, 16'd8);
    uut.imem[3] = enc_i(6'b000100, 5'd1, 5'd3, 16'd5);
    uut.imem[4] = enc_i(6'b000100, 5'd1, 5'd2, 16'd3);
    uut.imem[8] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFD);
    release_rst();
    step(); step(); step();
    chk("R6", "rf_we on beq", {31'd0, rf_we}, 32'd0);
    chk("R6", "dm_we on beq", {31'd0, dm_we}, 32'd0);
    step(); chk("R6", "not taken", pc_out, 32'd16);
    step(); chk("R6", "taken forward", pc_out, 32'd32);
    step(); chk("R6", "taken backward", pc_out, 32'd24);
    step(); chk("R1", "sequential after", pc_out, 32'd28);
  endtask

  task automatic t_jump();
    hold();
    uut.imem[0]  = enc_j(26'h10);
    uut.imem[16] = enc_j(26'h8);
    release_rst();
    step(); chk("R7", "jump 0x40", pc_out, 32'h40);
    step(); chk("R7", "jump 0x20", pc_out, 32'h20);
  endtask

  task automatic t_zero();
    hold();
    uut.dmem[0] = 32'd9;
    uut.imem[0] = lw(5'd0, 5'd0, 16'd0);
    uut.imem[1] = enc_r(5'd0, 5'd0, 5'd1, 6'b100101);
    uut.imem[2] = lw(5'd0, 5'd2, 16'd0);
    uut.imem[3] = enc_r(5'd2, 5'd0, 5'd3, 6'b100000);
    release_rst();
    chk("R8", "write to r0", {31'd0, rf_we}, 32'd0);
    step(); chk_wr("R8", 5'd1, 32'd0);
    step(); step(); chk_wr("R8", 5'd3, 32'd9);
  endtask

  task automatic t_nop();
    hold();
    uut.dmem[0] = 32'd3;
    uut.imem[1] = enc_i(6'b001000, 5'd0, 5'd1, 16'd5);
    uut.imem[2] = enc_r(5'd1, 5'd0, 5'd4, 6'b100000);
    release_rst();
    chk("R9", "rf_we", {31'd0, rf_we}, 32'd0);
    chk("R9", "dm_we", {31'd0, dm_we}, 32'd0);
    step();
    chk("R9", "pc", pc_out, 32'd4);
    chk("R9", "rf_we 2", {31'd0, rf_we}, 32'd0);
    step();
    chk_wr("R9", 5'd4, 32'd0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_jump();
    t_zero();
    t_nop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule